// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block owns the wiper registers of a two-channel digital potentiometer together with their nonvolatile shadow copies and a small bank of user constant bytes. It moves values between the volatile and nonvolatile sides on request and reports progress on an active-high ready output, `rdy`. `rdy` drops while a timed transfer is in flight and rises again only once the copy has landed. The command unit issues five operation codes on a one-cycle request strobe:
- save one wiper,
- restore one wiper,
- restore both wipers,
- write a user byte,
- read a user byte.

It may also load a wiper directly while the sequencer is idle.

The same restore-both path serves three triggers: leaving power-on reset, a low pulse on the asynchronous preset pin, and the serial command. Each operation class has its own busy length, given by a cycle-count parameter. Saves are the longest, a full restore is shorter, and single restores and user reads are the shortest. A write-protect input turns every nonvolatile write into a no-op. The nonvolatile array is a register array whose contents survive `rst_n`.

The controller has three states:
- `ST_IDLE`: ready, accepting requests.
- `ST_WAIT`: timed busy period.
- `ST_COMMIT`: one cycle in which the copy is made.

Its transitions are:
- reset enters `ST_WAIT` with a restore-both pending.
- `ST_IDLE` goes to `ST_WAIT` on an accepted request or a preset edge.
- `ST_WAIT` goes to `ST_COMMIT` when the countdown reaches zero.
- `ST_COMMIT` returns to `ST_IDLE` unconditionally.

Top module: `nv_recall_seq`

## Requirements
- R1: Operation codes on `req_op` are 1 = save wiper, 2 = restore one wiper, 3 = restore both, 4 = user write, 5 = user read. Codes 0, 6 and 7 are ignored. A channel index (`req_idx`) of N_CH or more is ignored for codes 1 and 2, and a user index of USER_N or more is ignored for codes 4 and 5. An ignored request leaves `rdy` high and changes no state.
- R2: A save copies the wiper selected by `req_idx` into its nonvolatile shadow. `rdy` is low for STORE_CYC+1 cycles, counted from the cycle after the accepting edge.
- R3: A restore-one copies that channel's shadow into its wiper. `rdy` is low for RECALL_ONE_CYC+1 cycles.
- R4: A restore-both copies every shadow into its wiper. `rdy` is low for RECALL_ALL_CYC+1 cycles.
- R5: While `rst_n` is low, `rdy` is low and both wipers read 0. After release, `rdy` stays low for RECALL_ALL_CYC cycles and then rises with both wipers equal to their shadows. Shadows start at NV_INIT (0x80) and keep their values across `rst_n`.
- R6: A falling edge on `preset_n` seen by an idle sequencer (after a two-flop synchronizer) runs a restore-both, with `rdy` low for RECALL_ALL_CYC+1 cycles.
- R7: With `wr_prot` high at acceptance, codes 1 and 4 finish at once with no busy period and leave nonvolatile contents unchanged.
- R8: A user write stores `req_data` at user byte `req_idx` with the save busy length. A user read returns that byte on `rd_data` by the time `rdy` rises, with the restore-one busy length. Unwritten bytes read NV_INIT.
- R9: While `rdy` is low, requests and direct loads are dropped. Wipers change only on the edge at which `rdy` rises, and nonvolatile contents change only on that same edge.
- R10: With `rdy` high, `ld_en` writes `ld_data` into the wiper picked by `ld_chan` on the next edge, without lowering `rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| preset_n | input | 1 | Asynchronous preset, active-low pulse |
| wr_prot | input | 1 | Blocks all nonvolatile writes when high |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 3 | Operation code |
| req_idx | input | IDX_W (4) | Channel or user byte index |
| req_data | input | W (8) | Data for a user write |
| ld_en | input | 1 | Direct wiper load strobe |
| ld_chan | input | CH_W (1) | Wiper selected for a direct load |
| ld_data | input | W (8) | Direct load value |
| rdy | output | 1 | High when idle, low while a transfer runs |
| wiper_o | output | N_CH*W (16) | Wiper values, channel 0 in the low byte |
| rd_data | output | W (8) | Last user byte read |

## Verification
The bound checker watches these properties on every cycle:
- a save or restore commit moves exactly the selected value,
- wipers stay frozen through the countdown,
- nonvolatile contents move only in the commit cycle,
- ignored or write-protected requests never lower `rdy`,
- `rdy` only falls for one of the five legal codes.

Other behaviours show only in the bench's scenarios, which count busy lengths at the ports and replay the effects against a model:
- the exact per-class busy lengths,
- boot and preset restores,
- survival of shadows across reset,
- user byte round trips,
- dropped traffic during a busy period.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_STORE      = 3'd1,
        OP_RECALL_ONE = 3'd2,
        OP_RECALL_ALL = 3'd3,
        OP_USER_WR    = 3'd4,
        OP_USER_RD    = 3'd5,
        OP_RSV6       = 3'd6,
        OP_RSV7       = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_COMMIT = 2'd2
    } state_e;

endpackage

// File: rtl/nvseq_preset_sync.sv
module nvseq_preset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall_o
);
    logic [STAGES:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shreg <= '1;
        else        shreg <= {shreg[STAGES-1:0], pin_n};
    end

    // previous synchronized level high, current synchronized level low
    assign fall_o = shreg[STAGES] & ~shreg[STAGES-1];
endmodule

// File: rtl/nvseq_timer.sv
module nvseq_timer #(
    parameter int               CNT_W   = 8,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cnt_q <= RST_VAL;
        else if (load)                     cnt_q <= load_val;
        else if (run && cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nvseq_nvmem.sv
module nvseq_nvmem #(
    parameter int           W     = 8,
    parameter int           DEPTH = 16,
    parameter int           AW    = 4,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic               clk,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  logic [W-1:0]       wdata,
    output logic [DEPTH*W-1:0] cells_o
);
    // contents are deliberately outside the reset domain: they model storage
    // that keeps its value across power-on reset
    logic [DEPTH-1:0][W-1:0] cells = {DEPTH{INIT}};

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign cells_o = cells;
endmodule

// File: rtl/nv_recall_seq.sv
module nv_recall_seq
    import nvseq_pkg::*;
#(
    parameter int           W              = 8,
    parameter int           N_CH           = 2,
    parameter int           USER_N         = 14,
    parameter int           STORE_CYC      = 5000,
    parameter int           RECALL_ALL_CYC = 250,
    parameter int           RECALL_ONE_CYC = 30,
    parameter logic [W-1:0] NV_INIT        = 8'h80,
    parameter int           IDX_W          = $clog2(USER_N),
    parameter int           CH_W           = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                preset_n,
    input  logic                wr_prot,
    input  logic                req_valid,
    input  logic [2:0]          req_op,
    input  logic [IDX_W-1:0]    req_idx,
    input  logic [W-1:0]        req_data,
    input  logic                ld_en,
    input  logic [CH_W-1:0]     ld_chan,
    input  logic [W-1:0]        ld_data,
    output logic                rdy,
    output logic [N_CH*W-1:0]   wiper_o,
    output logic [W-1:0]        rd_data
);
    localparam int DEPTH   = N_CH + USER_N;
    localparam int AW      = $clog2(DEPTH);
    localparam int MAX_A   = (STORE_CYC > RECALL_ALL_CYC) ? STORE_CYC : RECALL_ALL_CYC;
    localparam int MAX_CYC = (MAX_A > RECALL_ONE_CYC) ? MAX_A : RECALL_ONE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    state_e            state_q, state_d;
    op_e               op_q, op_in, op_start;
    logic [IDX_W-1:0]  idx_q;
    logic [W-1:0]      data_q;
    logic [W-1:0]      rd_q;

    logic              preset_evt;
    logic              zero;
    logic              accept, start, idle;
    logic              req_ok;
    logic [CNT_W-1:0]  req_len, load_val;

    logic              nv_we;
    logic [AW-1:0]     nv_waddr;
    logic [W-1:0]      nv_wdata;
    logic [DEPTH*W-1:0] nv_flat;
    logic [W-1:0]      store_src;
    logic [W-1:0]      user_src;

    // ---------------- submodules ----------------
    nvseq_preset_sync #(.STAGES(2)) u_psync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (preset_n),
        .fall_o (preset_evt)
    );

    nvseq_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (CNT_W'(RECALL_ALL_CYC - 1))
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .load_val (load_val),
        .run      (state_q == ST_WAIT),
        .zero_o   (zero)
    );

    nvseq_nvmem #(
        .W     (W),
        .DEPTH (DEPTH),
        .AW    (AW),
        .INIT  (NV_INIT)
    ) u_nvmem (
        .clk     (clk),
        .we      (nv_we),
        .waddr   (nv_waddr),
        .wdata   (nv_wdata),
        .cells_o (nv_flat)
    );

    // ---------------- request decode ----------------
    assign op_in = op_e'(req_op);
    assign idle  = (state_q == ST_IDLE);

    always_comb begin
        req_ok  = 1'b0;
        req_len = CNT_W'(RECALL_ONE_CYC - 1);
        unique case (op_in)
            OP_STORE: begin
                req_ok  = (int'(req_idx) < N_CH) && !wr_prot;
                req_len = CNT_W'(STORE_CYC - 1);
            end
            OP_RECALL_ONE: begin
                req_ok  = (int'(req_idx) < N_CH);
                req_len = CNT_W'(RECALL_ONE_CYC - 1);
            end
            OP_RECALL_ALL: begin
                req_ok  = 1'b1;
                req_len = CNT_W'(RECALL_ALL_CYC - 1);
            end
            OP_USER_WR: begin
                req_ok  = (int'(req_idx) < USER_N) && !wr_prot;
                req_len = CNT_W'(STORE_CYC - 1);
            end
            OP_USER_RD: begin
                req_ok  = (int'(req_idx) < USER_N);
                req_len = CNT_W'(RECALL_ONE_CYC - 1);
            end
            OP_NONE, OP_RSV6, OP_RSV7: begin
                req_ok  = 1'b0;
            end
        endcase
    end

    // preset has priority over a request in the same cycle
    assign accept   = idle && req_valid && req_ok && !preset_evt;
    assign start    = idle && (preset_evt || accept);
    assign op_start = preset_evt ? OP_RECALL_ALL : op_in;
    assign load_val = preset_evt ? CNT_W'(RECALL_ALL_CYC - 1) : req_len;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            op_q    <= OP_RECALL_ALL;
            idx_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                op_q   <= op_start;
                idx_q  <= req_idx;
                data_q <= req_data;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_WAIT;
            ST_WAIT:   if (zero)  state_d = ST_COMMIT;
            ST_COMMIT:            state_d = ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs and commit controls ----------------
    always_comb begin
        store_src = '0;
        for (int c = 0; c < N_CH; c++)
            if (int'(idx_q) == c) store_src = wiper_o[c*W +: W];
        user_src = '0;
        for (int u = 0; u < USER_N; u++)
            if (int'(idx_q) == u) user_src = nv_flat[(N_CH+u)*W +: W];

        rdy      = idle;
        nv_we    = 1'b0;
        nv_waddr = '0;
        nv_wdata = '0;
        if (state_q == ST_COMMIT) begin
            unique case (op_q)
                OP_STORE: begin
                    nv_we    = 1'b1;
                    nv_waddr = AW'(idx_q);
                    nv_wdata = store_src;
                end
                OP_USER_WR: begin
                    nv_we    = 1'b1;
                    nv_waddr = AW'(N_CH) + AW'(idx_q);
                    nv_wdata = data_q;
                end
                OP_NONE, OP_RECALL_ONE, OP_RECALL_ALL,
                OP_USER_RD, OP_RSV6, OP_RSV7: nv_we = 1'b0;
            endcase
        end
    end

    // ---------------- wiper registers ----------------
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [W-1:0] w_q;
        logic         recall_hit, load_hit;

        assign recall_hit = (state_q == ST_COMMIT) &&
                            ((op_q == OP_RECALL_ALL) ||
                             (op_q == OP_RECALL_ONE && int'(idx_q) == c));
        assign load_hit   = idle && ld_en && (int'(ld_chan) == c);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          w_q <= '0;
            else if (recall_hit) w_q <= nv_flat[c*W +: W];
            else if (load_hit)   w_q <= ld_data;
        end

        assign wiper_o[c*W +: W] = w_q;
    end

    // ---------------- user byte readback ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                         rd_q <= '0;
        else if (state_q == ST_COMMIT && op_q == OP_USER_RD) rd_q <= user_src;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/nv_recall_seq_chk.sv
module nv_recall_seq_chk
    import nvseq_pkg::*;
#(
    parameter int W     = 8,
    parameter int N_CH  = 2,
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rdy,
    input logic               wr_prot,
    input logic               req_valid,
    input logic [2:0]         req_op,
    input logic               evt_i,
    input logic [1:0]         st_i,
    input logic [2:0]         op_i,
    input logic [IDX_W-1:0]   idx_i,
    input logic [N_CH*W-1:0]  wiper_o,
    input logic [DEPTH*W-1:0] nv_i
);
    for (genvar c = 0; c < N_CH; c++) begin : g_pc
        // R2: a save commit lands the wiper value in its shadow
        a_r2_store_copy: assert property (@(posedge clk) disable iff (!rst_n)
            (st_i == 2'(ST_COMMIT) && op_i == 3'(OP_STORE) && int'(idx_i) == c)
            |=> nv_i[c*W +: W] == $past(wiper_o[c*W +: W]));

        // R3: a single restore commit lands the shadow in its wiper
        a_r3_recall_copy: assert property (@(posedge clk) disable iff (!rst_n)
            (st_i == 2'(ST_COMMIT) && op_i == 3'(OP_RECALL_ONE) && int'(idx_i) == c)
            |=> wiper_o[c*W +: W] == $past(nv_i[c*W +: W]));

        // R4: a restore-both commit lands every shadow in its wiper
        a_r4_recall_all: assert property (@(posedge clk) disable iff (!rst_n)
            (st_i == 2'(ST_COMMIT) && op_i == 3'(OP_RECALL_ALL))
            |=> wiper_o[c*W +: W] == $past(nv_i[c*W +: W]));
    end

    // R9: wipers frozen through the countdown
    a_r9_wiper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_i == 2'(ST_WAIT)) |=> $stable(wiper_o));

    // R9: nonvolatile contents move only in the commit cycle
    a_r9_nv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_i != 2'(ST_COMMIT)) |=> $stable(nv_i));

    // R7: protected store-class request never starts a busy period
    a_r7_wp_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && wr_prot && req_valid && !evt_i &&
         (req_op == 3'(OP_STORE) || req_op == 3'(OP_USER_WR))) |=> rdy);

    // R1: reserved codes never start a busy period
    a_r1_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && req_valid && !evt_i &&
         (req_op == 3'd0 || req_op == 3'd6 || req_op == 3'd7)) |=> rdy);

    // R1: rdy only falls for one of the five legal codes
    a_r1_busy_legal: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> (op_i >= 3'd1 && op_i <= 3'd5));
endmodule

bind nv_recall_seq nv_recall_seq_chk #(
    .W     (W),
    .N_CH  (N_CH),
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rdy       (rdy),
    .wr_prot   (wr_prot),
    .req_valid (req_valid),
    .req_op    (req_op),
    .evt_i     (preset_evt),
    .st_i      (state_q),
    .op_i      (op_q),
    .idx_i     (idx_q),
    .wiper_o   (wiper_o),
    .nv_i      (nv_flat)
);

// File: tb/nv_recall_seq_tb.sv
`timescale 1ns/1ps
module nv_recall_seq_tb;
    localparam int STORE_C = 200;
    localparam int ALL_C   = 24;
    localparam int ONE_C   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        preset_n = 1'b1;
    logic        wr_prot = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [3:0]  req_idx = '0;
    logic [7:0]  req_data = '0;
    logic        ld_en = 1'b0;
    logic [0:0]  ld_chan = '0;
    logic [7:0]  ld_data = '0;
    logic        rdy;
    logic [15:0] wiper_o;
    logic [7:0]  rd_data;

    always #2 clk = ~clk;

    nv_recall_seq #(
        .STORE_CYC      (STORE_C),
        .RECALL_ALL_CYC (ALL_C),
        .RECALL_ONE_CYC (ONE_C)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .preset_n (preset_n), .wr_prot (wr_prot),
        .req_valid (req_valid), .req_op (req_op), .req_idx (req_idx),
        .req_data (req_data), .ld_en (ld_en), .ld_chan (ld_chan),
        .ld_data (ld_data), .rdy (rdy), .wiper_o (wiper_o), .rd_data (rd_data)
    );

    typedef struct {
        string       tag;
        logic [15:0] wip;
        logic [7:0]  rd;
        bit          chk_rd;
        int          len;
    } item_t;

    item_t      exp_q[$];
    int         n_chk = 0;
    int         n_fail = 0;
    int         low_cnt = 0;
    logic [7:0] m_wip [2];
    logic [7:0] m_nv  [16];

    function automatic logic [15:0] pack_wip();
        return {m_wip[1], m_wip[0]};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- monitor: pops one item per completed transfer ----------------
    always @(negedge clk) begin
        if (!rst_n) begin
            low_cnt = 0;
        end else if (!rdy) begin
            low_cnt++;
        end else begin
            if (low_cnt > 0) begin
                if (exp_q.size() == 0) begin
                    chk("R9", "unexpected transfer", 32'(low_cnt), 32'd0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk(it.tag, "busy cycles", 32'(low_cnt), 32'(it.len));
                    chk(it.tag, "wipers", 32'(wiper_o), 32'(it.wip));
                    if (it.chk_rd) chk(it.tag, "rd_data", 32'(rd_data), 32'(it.rd));
                end
            end
            low_cnt = 0;
        end
    end

    task automatic wait_done();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic issue(input logic [2:0] op, input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_idx = idx; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // R10 direct load, checked one edge later
    task automatic do_load(input int ch, input logic [7:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_chan = 1'(ch); ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
        m_wip[ch] = v;
        chk("R10", "direct load wipers", 32'(wiper_o), 32'(pack_wip()));
        chk("R10", "direct load rdy", 32'(rdy), 32'd1);
    endtask

    // driver: model the operation, push the expected item, issue, wait
    task automatic run_op(input string tag, input logic [2:0] op,
                          input logic [3:0] idx, input logic [7:0] d);
        item_t it;
        it.tag = tag; it.chk_rd = 1'b0; it.rd = '0;
        case (op)
            3'd1: begin m_nv[idx] = m_wip[idx]; it.len = STORE_C + 1; end
            3'd2: begin m_wip[idx] = m_nv[idx]; it.len = ONE_C + 1; end
            3'd3: begin m_wip[0] = m_nv[0]; m_wip[1] = m_nv[1]; it.len = ALL_C + 1; end
            3'd4: begin m_nv[2+idx] = d; it.len = STORE_C + 1; end
            default: begin it.rd = m_nv[2+idx]; it.chk_rd = 1'b1; it.len = ONE_C + 1; end
        endcase
        it.wip = pack_wip();
        exp_q.push_back(it);
        issue(op, idx, d);
        wait_done();
    endtask

    // request that must be ignored: rdy stays high, wipers unchanged
    task automatic ignored(input string req, input logic [2:0] op,
                           input logic [3:0] idx, input logic [7:0] d);
        issue(op, idx, d);
        chk(req, "ignored rdy", 32'(rdy), 32'd1);
        @(negedge clk);
        chk(req, "ignored rdy later", 32'(rdy), 32'd1);
        chk(req, "ignored wipers", 32'(wiper_o), 32'(pack_wip()));
    endtask

    task automatic do_reset(input string tag);
        item_t it;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R5", "rdy during reset", 32'(rdy), 32'd0);
        chk("R5", "wipers during reset", 32'(wiper_o), 32'd0);
        m_wip[0] = m_nv[0]; m_wip[1] = m_nv[1];
        it.tag = tag; it.wip = pack_wip(); it.rd = '0; it.chk_rd = 1'b0; it.len = ALL_C;
        exp_q.push_back(it);
        @(negedge clk);
        #1 rst_n = 1'b1;
        wait_done();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        item_t pit;
        for (int i = 0; i < 16; i++) m_nv[i] = 8'h80;
        m_wip[0] = 8'h00; m_wip[1] = 8'h00;

        // R5 boot restore from initial shadows
        do_reset("R5 boot restore");

        // R10 direct loads
        do_load(0, 8'h11);
        do_load(1, 8'h22);

        // R2 save both channels
        run_op("R2 save ch0", 3'd1, 4'd0, 8'h00);
        run_op("R2 save ch1", 3'd1, 4'd1, 8'h00);

        // R3 restore one
        do_load(0, 8'h55);
        run_op("R3 restore ch0", 3'd2, 4'd0, 8'h00);

        // R4 restore both
        do_load(0, 8'h99);
        do_load(1, 8'h77);
        run_op("R4 restore both", 3'd3, 4'd0, 8'h00);

        // R7 write protect: save and user write are no-ops
        do_load(0, 8'hAA);
        wr_prot = 1'b1;
        ignored("R7", 3'd1, 4'd0, 8'h00);
        ignored("R7", 3'd4, 4'd3, 8'h5A);
        wr_prot = 1'b0;
        run_op("R7 shadow kept", 3'd2, 4'd0, 8'h00);

        // R8 user bytes
        run_op("R8 user write", 3'd4, 4'd3, 8'hC3);
        run_op("R8 user read", 3'd5, 4'd3, 8'h00);
        run_op("R8 unwritten read", 3'd5, 4'd5, 8'h00);
        run_op("R8 last byte write", 3'd4, 4'd13, 8'h3E);
        run_op("R8 last byte read", 3'd5, 4'd13, 8'h00);
        wr_prot = 1'b1;
        ignored("R7", 3'd4, 4'd3, 8'h00);
        wr_prot = 1'b0;
        run_op("R7 user byte kept", 3'd5, 4'd3, 8'h00);

        // R1 ignored codes and out-of-range indices
        ignored("R1", 3'd0, 4'd0, 8'h00);
        ignored("R1", 3'd6, 4'd0, 8'h00);
        ignored("R1", 3'd7, 4'd1, 8'h00);
        ignored("R1", 3'd1, 4'd2, 8'h00);
        ignored("R1", 3'd2, 4'd3, 8'h00);
        ignored("R1", 3'd4, 4'd14, 8'h12);
        ignored("R1", 3'd5, 4'd15, 8'h00);

        // R9 traffic during busy is dropped
        do_load(0, 8'h44);
        m_nv[0] = 8'h44;
        pit.tag = "R9 save with dropped traffic"; pit.wip = pack_wip();
        pit.rd = '0; pit.chk_rd = 1'b0; pit.len = STORE_C + 1;
        exp_q.push_back(pit);
        issue(3'd1, 4'd0, 8'h00);
        repeat (3) @(negedge clk);
        ld_en = 1'b1; ld_chan = 1'b1; ld_data = 8'hEE;
        @(negedge clk);
        ld_en = 1'b0;
        chk("R9", "load dropped while busy", 32'(wiper_o), 32'(pack_wip()));
        issue(3'd3, 4'd0, 8'h00);
        wait_done();
        @(negedge clk);
        chk("R9", "no late transfer", 32'(rdy), 32'd1);
        chk("R9", "wipers after busy", 32'(wiper_o), 32'(pack_wip()));

        // R6 preset pulse restores both
        do_load(0, 8'h01);
        do_load(1, 8'h02);
        m_wip[0] = m_nv[0]; m_wip[1] = m_nv[1];
        pit.tag = "R6 preset restore"; pit.wip = pack_wip();
        pit.rd = '0; pit.chk_rd = 1'b0; pit.len = ALL_C + 1;
        exp_q.push_back(pit);
        @(negedge clk);
        preset_n = 1'b0;
        repeat (3) @(negedge clk);
        preset_n = 1'b1;
        wait_done();

        // R5 shadows survive a second reset
        do_load(1, 8'h66);
        run_op("R2 save ch1 before reset", 3'd1, 4'd1, 8'h00);
        do_load(0, 8'h0F);
        do_load(1, 8'hF0);
        do_reset("R5 shadows kept across reset");

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule